// File: doc/BRIEF.md
# Vector Compare to Predicate Bit Unit

This unit sits after instruction decode in a core that can mark integer registers as vectors and as predicate masks. When a conditional-branch encoding, either the full 32-bit form or the 16-bit compressed form, names a vectorised source and a predicate-tagged target, the unit does not branch. It evaluates the compare for one vector element and produces a single-bit write into the target predicate register, at the position given by the current element index. The looping logic upstream calls it once per element.

The compressed form reuses its offset field. It carries a 3-bit predicate target, a second 3-bit source, an integer/float flag and a compare modifier. The float path orders raw 32-bit single-precision patterns. When neither source is vectorised, or the target is not tagged as a predicate, the unit reports the instruction as an ordinary branch so that the normal branch path can handle it. The unit does not compute branch targets.

Top module: `cmpp_unit`

## Requirements
- R1: A 32-bit instruction (in_is_c=0) is recognised when bits 6..0 equal 1100011 and funct3 (bits 14..12) is 000 EQ, 001 NE, 100 signed LT or 101 signed GE. The first source register is bits 19..15, the second is bits 24..20, and the predicate target register is bits 11..7.
- R2: A compressed instruction (in_is_c=1) is recognised when bits 1..0 equal 01 and bits 15..13 are 110 or 111. Target, first source and second source are the 3-bit fields at 12..10, 9..7 and 4..2, each naming register 8 plus the field. The compare is picked by {bit 13, bit 5}: 00 EQ, 01 NE, 10 LT, 11 LE.
- R3: In the compressed form, bit 6 = 0 compares both operands as signed integers and bit 6 = 1 compares them as single-precision patterns by numeric order.
- R4: In float compares, +0 and -0 are equal. If either operand is a NaN (exponent all ones, mantissa non-zero), EQ, LT and LE give 0 and NE gives 1.
- R5: If either source register is set in vec_map and the target is set in pred_tag_map, the unit raises out_pred_we. It puts the target on out_pred_reg, the element index on out_pred_idx, and 1 on out_pred_bit if the compare holds or 0 if it does not.
- R6: A recognised instruction that does not meet the R5 condition raises out_branch and does not write. out_pred_we and out_branch are never high together.
- R7: An unrecognised encoding raises neither output. Bits 31..25 of the 32-bit form, and bits 31..16 when in_is_c=1, do not affect the result.
- R8: Results appear one clock after in_valid is sampled high, and outputs are low in any cycle that follows a cycle with in_valid low. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands valid this cycle |
| in_is_c | input | 1 | 1: low 16 bits hold a compressed instruction |
| in_instr | input | 32 | Instruction word |
| in_src1 | input | 32 | Current element value of the first source |
| in_src2 | input | 32 | Current element value of the second source |
| in_elem_idx | input | IDX_W | Current vector element index |
| vec_map | input | 32 | Per-register vectorised flag |
| pred_tag_map | input | 32 | Per-register predicate-tag flag |
| out_pred_we | output | 1 | Predicate bit write strobe |
| out_pred_reg | output | 5 | Predicate register written |
| out_pred_idx | output | IDX_W | Bit position written |
| out_pred_bit | output | 1 | Value written |
| out_branch | output | 1 | Handle as ordinary branch |

## Verification
The compare is driven with equal and unequal operands, with signed values that straddle zero, and with float patterns that order in opposite directions as integers and as floats (-1.0 against -2.0). This last case shows whether bit 6 really switches the comparator. Signed zeros and a quiet NaN separate ordered from unordered float handling. Varying which registers are vectorised or tagged shows the write path, the branch fallback and the recognition of other encodings as separate cases. Reserved bits are set on an otherwise identical instruction to show that they are ignored.

// File: rtl/cmpp_pkg.sv
package cmpp_pkg;

    localparam int REG_W  = 5;
    localparam int NREG   = 1 << REG_W;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_NE,
        CMP_LT,
        CMP_LE,
        CMP_GE
    } cmp_op_e;

    typedef struct packed {
        logic             hit;
        logic             is_fp;
        cmp_op_e          op;
        logic [REG_W-1:0] tgt;
        logic [REG_W-1:0] rs_a;
        logic [REG_W-1:0] rs_b;
    } dec_t;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [1:0] OPC_CQ1    = 2'b01;

    function automatic logic [REG_W-1:0] creg(input logic [2:0] f);
        return {2'b01, f};
    endfunction

    function automatic logic is_nan(input logic [DATA_W-1:0] x);
        return (&x[30:23]) && (|x[22:0]);
    endfunction

endpackage

// File: rtl/cmpp_decode.sv
module cmpp_decode
    import cmpp_pkg::*;
(
    input  logic        is_c,
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic unused_rsvd;
    assign unused_rsvd = ^instr[31:25];

    dec_t d32, d16;

    always_comb begin
        d32       = '0;
        d32.tgt   = instr[11:7];
        d32.rs_a  = instr[19:15];
        d32.rs_b  = instr[24:20];
        d32.is_fp = 1'b0;
        d32.hit   = (instr[6:0] == OPC_BRANCH);
        unique case (instr[14:12])
            3'b000:  d32.op = CMP_EQ;
            3'b001:  d32.op = CMP_NE;
            3'b100:  d32.op = CMP_LT;
            3'b101:  d32.op = CMP_GE;
            default: begin
                d32.op  = CMP_EQ;
                d32.hit = 1'b0;
            end
        endcase
    end

    always_comb begin
        d16       = '0;
        d16.hit   = (instr[1:0] == OPC_CQ1) && (instr[15:14] == 2'b11);
        d16.tgt   = creg(instr[12:10]);
        d16.rs_a  = creg(instr[9:7]);
        d16.rs_b  = creg(instr[4:2]);
        d16.is_fp = instr[6];
        unique case ({instr[13], instr[5]})
            2'b00:   d16.op = CMP_EQ;
            2'b01:   d16.op = CMP_NE;
            2'b10:   d16.op = CMP_LT;
            default: d16.op = CMP_LE;
        endcase
    end

    assign dec = is_c ? d16 : d32;

endmodule

// File: rtl/cmpp_compare.sv
module cmpp_compare
    import cmpp_pkg::*;
(
    input  cmp_op_e           op,
    input  logic              is_fp,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              res
);
    logic i_eq, i_lt, f_eq, f_lt, unord, both_zero, mag_lt, mag_gt;
    logic eq, lt;

    always_comb begin
        i_eq      = (a == b);
        i_lt      = ($signed(a) < $signed(b));
        unord     = is_nan(a) || is_nan(b);
        both_zero = (a[30:0] == '0) && (b[30:0] == '0);
        mag_lt    = (a[30:0] < b[30:0]);
        mag_gt    = (a[30:0] > b[30:0]);
        f_eq      = !unord && (i_eq || both_zero);
        if (unord || both_zero)
            f_lt = 1'b0;
        else if (a[31] != b[31])
            f_lt = a[31];
        else
            f_lt = a[31] ? mag_gt : mag_lt;
        eq = is_fp ? f_eq : i_eq;
        lt = is_fp ? f_lt : i_lt;
        unique case (op)
            CMP_EQ:  res = eq;
            CMP_NE:  res = !eq;
            CMP_LT:  res = lt;
            CMP_LE:  res = lt || eq;
            CMP_GE:  res = !lt;
            default: res = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmpp_unit.sv
module cmpp_unit
    import cmpp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_is_c,
    input  logic [31:0]       in_instr,
    input  logic [31:0]       in_src1,
    input  logic [31:0]       in_src2,
    input  logic [IDX_W-1:0]  in_elem_idx,
    input  logic [31:0]       vec_map,
    input  logic [31:0]       pred_tag_map,
    output logic              out_pred_we,
    output logic [4:0]        out_pred_reg,
    output logic [IDX_W-1:0]  out_pred_idx,
    output logic              out_pred_bit,
    output logic              out_branch
);
    dec_t dec;
    logic cmp_res;
    logic pred_mode;

    cmpp_decode u_dec (
        .is_c  (in_is_c),
        .instr (in_instr),
        .dec   (dec)
    );

    cmpp_compare u_cmp (
        .op    (dec.op),
        .is_fp (dec.is_fp),
        .a     (in_src1),
        .b     (in_src2),
        .res   (cmp_res)
    );

    assign pred_mode = (vec_map[dec.rs_a] || vec_map[dec.rs_b]) && pred_tag_map[dec.tgt];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_pred_we  <= 1'b0;
            out_branch   <= 1'b0;
            out_pred_reg <= '0;
            out_pred_idx <= '0;
            out_pred_bit <= 1'b0;
        end else begin
            out_pred_we  <= in_valid && dec.hit && pred_mode;
            out_branch   <= in_valid && dec.hit && !pred_mode;
            out_pred_reg <= dec.tgt;
            out_pred_idx <= in_elem_idx;
            out_pred_bit <= cmp_res;
        end
    end

endmodule

// File: rtl/cmpp_unit_chk.sv
module cmpp_unit_chk #(
    parameter int IDX_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_is_c,
    input logic [31:0]       in_instr,
    input logic [IDX_W-1:0]  in_elem_idx,
    input logic [31:0]       pred_tag_map,
    input logic              out_pred_we,
    input logic [4:0]        out_pred_reg,
    input logic [IDX_W-1:0]  out_pred_idx,
    input logic              out_branch
);
    logic [31:0] tag_q;
    always_ff @(posedge clk) tag_q <= pred_tag_map;

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(out_pred_we && out_branch)); // R6
    AST_NO_VALID_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (!out_pred_we && !out_branch)); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_pred_we && !out_branch)); // R8
    AST_IDX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        out_pred_we |-> (out_pred_idx == $past(in_elem_idx))); // R5
    AST_TARGET_TAGGED: assert property (@(posedge clk) disable iff (rst)
        out_pred_we |-> tag_q[out_pred_reg]); // R5
    AST_C_TARGET_RANGE: assert property (@(posedge clk) disable iff (rst)
        (out_pred_we && $past(in_is_c)) |-> (out_pred_reg[4:3] == 2'b01)); // R2
    AST_W_TARGET_FIELD: assert property (@(posedge clk) disable iff (rst)
        (out_pred_we && !$past(in_is_c)) |-> (out_pred_reg == $past(in_instr[11:7]))); // R1

endmodule

bind cmpp_unit cmpp_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_is_c      (in_is_c),
    .in_instr     (in_instr),
    .in_elem_idx  (in_elem_idx),
    .pred_tag_map (pred_tag_map),
    .out_pred_we  (out_pred_we),
    .out_pred_reg (out_pred_reg),
    .out_pred_idx (out_pred_idx),
    .out_branch   (out_branch)
);

// File: tb/cmpp_unit_tb.sv
module cmpp_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 4;

    typedef struct packed {
        logic             we;
        logic [4:0]       rg;
        logic [IDX_W-1:0] idx;
        logic             bt;
        logic             br;
    } exp_t;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_is_c = 0;
    logic [31:0] in_instr = '0, in_src1 = '0, in_src2 = '0;
    logic [IDX_W-1:0] in_elem_idx = '0;
    logic [31:0] vec_map, pred_tag_map;
    logic out_pred_we, out_pred_bit, out_branch;
    logic [4:0] out_pred_reg;
    logic [IDX_W-1:0] out_pred_idx;

    int n_checks = 0, n_fail = 0;
    exp_t  q[$];
    string nq[$];
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpp_unit #(.IDX_W(IDX_W)) u_dut (.*);

    function automatic logic [31:0] w32(input logic [2:0] f3, input logic [4:0] tgt,
                                        input logic [4:0] s1, input logic [4:0] s2,
                                        input logic [6:0] rsv);
        return {rsv, s2, s1, f3, tgt, 7'b1100011};
    endfunction

    function automatic logic [31:0] w16(input logic [2:0] f3, input logic [2:0] tgt,
                                        input logic [2:0] s1, input logic fp, input logic m,
                                        input logic [2:0] s2, input logic [1:0] op);
        return {16'hA5C3, f3, tgt, s1, fp, m, s2, op};
    endfunction

    function automatic exp_t ew(input logic [4:0] rg, input logic [IDX_W-1:0] idx, input logic bt);
        return '{we: 1'b1, rg: rg, idx: idx, bt: bt, br: 1'b0};
    endfunction

    function automatic exp_t eb();
        return '{we: 1'b0, rg: '0, idx: '0, bt: 1'b0, br: 1'b1};
    endfunction

    function automatic exp_t en();
        return '0;
    endfunction

    task automatic send(input logic c, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic [IDX_W-1:0] idx,
                        input exp_t e, input string nm);
        @(negedge clk);
        in_valid = 1; in_is_c = c; in_instr = ins;
        in_src1 = a; in_src2 = b; in_elem_idx = idx;
        q.push_back(e);
        nq.push_back(nm);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    // monitor / scoreboard
    initial begin
        exp_t  e;
        string nm;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                nm = nq.pop_front();
            end else begin
                e = en();
                nm = rst ? "R8 reset state" : "R8 idle";
            end
            n_checks++;
            if (e.we) begin
                if (out_pred_we !== 1'b1 || out_branch !== 1'b0 || out_pred_reg !== e.rg ||
                    out_pred_idx !== e.idx || out_pred_bit !== e.bt) begin
                    n_fail++;
                    $display("FAIL %s: we=%b br=%b reg=%0d idx=%0d bit=%b expected we=1 br=0 reg=%0d idx=%0d bit=%b",
                             nm, out_pred_we, out_branch, out_pred_reg, out_pred_idx, out_pred_bit,
                             e.rg, e.idx, e.bt);
                end
            end else if (out_pred_we !== 1'b0 || out_branch !== e.br) begin
                n_fail++;
                $display("FAIL %s: we=%b br=%b expected we=0 br=%b",
                         nm, out_pred_we, out_branch, e.br);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // vectorised: 9, 10, 12 ; predicate-tagged: 3, 5, 9, 14
        vec_map      = (32'd1 << 9) | (32'd1 << 10) | (32'd1 << 12);
        pred_tag_map = (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 9) | (32'd1 << 14);
        repeat (3) @(negedge clk);
        rst = 0;
        idle();

        // R1 32-bit compares
        send(0, w32(3'b000, 5, 10, 2, 0), 32'd7, 32'd7, 3, ew(5, 3, 1), "R1 BEQ equal");
        send(0, w32(3'b000, 5, 10, 2, 0), 32'd7, 32'd8, 4, ew(5, 4, 0), "R1 BEQ unequal");
        send(0, w32(3'b001, 3, 2, 12, 0), 32'd1, 32'd2, 7, ew(3, 7, 1), "R1 BNE");
        send(0, w32(3'b100, 5, 10, 1, 0), 32'hFFFF_FFFF, 32'd1, 1, ew(5, 1, 1), "R1 BLT signed");
        send(0, w32(3'b101, 5, 10, 1, 0), 32'hFFFF_FFFF, 32'd1, 2, ew(5, 2, 0), "R1 BGE signed");
        send(0, w32(3'b101, 5, 10, 1, 0), 32'd9, 32'd9, 15, ew(5, 15, 1), "R1 BGE equal");
        idle();
        // R7 reserved bits ignored
        send(0, w32(3'b000, 5, 10, 2, 7'h7F), 32'd7, 32'd7, 6, ew(5, 6, 1), "R7 reserved bits set");
        // R7 unsupported funct3 and non-branch opcode
        send(0, w32(3'b110, 5, 10, 2, 0), 32'd1, 32'd2, 0, en(), "R7 funct3 110");
        send(0, w32(3'b000, 5, 10, 2, 0) ^ 32'h4, 32'd1, 32'd1, 0, en(), "R7 other opcode");
        // R6 fallbacks
        send(0, w32(3'b000, 5, 1, 2, 0), 32'd7, 32'd7, 0, eb(), "R6 no vector source");
        send(0, w32(3'b000, 4, 10, 2, 0), 32'd7, 32'd7, 0, eb(), "R6 target untagged");
        idle();

        // R2 compressed integer forms: tgt field 1 -> reg 9, src1 field 2 -> reg 10
        send(1, w16(3'b110, 1, 2, 0, 0, 3, 2'b01), 32'd5, 32'd5, 8, ew(9, 8, 1), "R2 C EQ");
        send(1, w16(3'b110, 1, 2, 0, 1, 3, 2'b01), 32'd5, 32'd5, 9, ew(9, 9, 0), "R2 C NE");
        send(1, w16(3'b111, 1, 2, 0, 0, 3, 2'b01), 32'hFFFF_FFFD, 32'd2, 10, ew(9, 10, 1), "R2 C LT signed");
        send(1, w16(3'b111, 1, 2, 0, 1, 3, 2'b01), 32'd2, 32'd2, 11, ew(9, 11, 1), "R2 C LE equal");
        send(1, w16(3'b111, 1, 2, 0, 1, 3, 2'b01), 32'd3, 32'd2, 12, ew(9, 12, 0), "R2 C LE greater");
        // R3 float versus integer ordering of -1.0 and -2.0
        send(1, w16(3'b111, 1, 2, 0, 0, 3, 2'b01), 32'hBF80_0000, 32'hC000_0000, 1, ew(9, 1, 1), "R3 int LT bits");
        send(1, w16(3'b111, 1, 2, 1, 0, 3, 2'b01), 32'hBF80_0000, 32'hC000_0000, 2, ew(9, 2, 0), "R3 float LT -1<-2");
        send(1, w16(3'b111, 1, 2, 1, 0, 3, 2'b01), 32'h3F80_0000, 32'h4000_0000, 3, ew(9, 3, 1), "R3 float LT 1<2");
        // R4 zeros and NaN
        send(1, w16(3'b110, 1, 2, 1, 0, 3, 2'b01), 32'h0000_0000, 32'h8000_0000, 4, ew(9, 4, 1), "R4 +0 EQ -0");
        send(1, w16(3'b111, 1, 2, 1, 0, 3, 2'b01), 32'h8000_0000, 32'h0000_0000, 5, ew(9, 5, 0), "R4 -0 LT +0");
        send(1, w16(3'b111, 1, 2, 1, 1, 3, 2'b01), 32'h7FC0_0000, 32'h3F80_0000, 6, ew(9, 6, 0), "R4 NaN LE");
        send(1, w16(3'b110, 1, 2, 1, 1, 3, 2'b01), 32'h7FC0_0000, 32'h7FC0_0000, 7, ew(9, 7, 1), "R4 NaN NE");
        idle();
        // R7 compressed non-matching encodings; R6 compressed fallback
        send(1, w16(3'b110, 1, 2, 0, 0, 3, 2'b10), 32'd5, 32'd5, 0, en(), "R7 C op 10");
        send(1, w16(3'b101, 1, 2, 0, 0, 3, 2'b01), 32'd5, 32'd5, 0, en(), "R7 C funct3 101");
        send(1, w16(3'b110, 1, 5, 0, 0, 6, 2'b01), 32'd5, 32'd5, 0, eb(), "R6 C no vector source");
        // R5 second source alone vectorised (field 4 -> reg 12), target field 6 -> reg 14
        send(1, w16(3'b110, 6, 5, 0, 0, 4, 2'b01), 32'd5, 32'd5, 13, ew(14, 13, 1), "R5 src2 vectorised");
        idle();
        idle();
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule